// File: doc/BRIEF.md
# SMBus Indexed Configuration Register Target

This block is an SMBus target that holds a small bank of byte-wide configuration registers and drives their contents straight to neighbouring logic. A host reaches it over an open-drain clock/data pair. The block samples that pair with a fast system clock and pulls the data line low only through an output-enable.

Every transfer is indexed. To write, the host addresses the target with 0xDC and sends a starting index. It then sends a byte count, which is acknowledged and discarded, and streams data bytes until it issues a stop. To read, the host addresses with 0xDC and sends the index. It then issues a repeated start and addresses with 0xDD. The target first returns the value of its count register and then returns register contents from the index onward. The host acknowledges each byte, sends a NACK after the last one and then a stop.

The index space has 16 slots and wraps from 15 back to 0. Only a handful of slots hold storage; the rest read as zero.

Top module: `smb_cfg_target`

## Requirements
- R1: After reset the SDA output-enable is low. The control register stores 0x05 (bits 7,6,5 = 0, bits 2,0 = 1), the enable register is 0xFF, the stop-select register is 0x00 and the count register (slot 8) is 0x09.
- R2: The 8-bit address byte 0xDC is acknowledged by pulling SDA low during the ninth clock. Any other address opening a transfer is not acknowledged, and SDA then stays released for the rest of that transfer, up to the stop.
- R3: In a write, the byte after 0xDC is the index, the next byte is a count that is acknowledged but not stored, and each further byte is written to the slot at the current index. Every one of these bytes is acknowledged.
- R4: The index advances by one after every data byte, written or read, and wraps from 15 to 0. Only the low 4 bits of the index byte are used.
- R5: In a read (0xDC, index, repeated start, 0xDD), the target first returns the count register (slot 8), MSB first. It then returns the readback of the slot at the index and of the slots after it.
- R6: A host ACK (SDA low on the ninth clock) after a returned byte makes the target send the next byte. A host NACK makes it release SDA until the next start or stop.
- R7: Control readback: bit 3 equals sense_i[1], bit 1 equals sense_i[0] and bit 4 is always 0. Writes to these three bits are ignored.
- R8: Slot 3 (reserved), slots 4 to 7 and slots 9 to 15 always read 0x00, and writes to them are ignored.
- R9: A stop anywhere, including in the middle of a byte, returns the block to idle with SDA released. The next transfer then works normally. A 0xDD address without an index sent earlier in the same transfer is not acknowledged.
- R10: SDA output-enable changes only after an SCL falling edge, a start or a stop, never while SCL is high otherwise.
- R11: A register output changes only as the result of a write strobe aimed at that register's own slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SMBus clock line level |
| sda_i | input | 1 | SMBus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| sense_i | input | 2 | Pin levels reflected in control bits 3 and 1 |
| ctrl_o | output | 8 | Control register readback view |
| oe_mask_o | output | 8 | Enable register (slot 1) |
| stop_sel_o | output | 8 | Stop-select register (slot 2) |
| xfer_cnt_o | output | 8 | Count register (slot 8) |

## Verification
The host model writes several bytes in a row from index 1, which checks that the index advances and that the count byte is dropped. It then writes across the top of the index space, which shows whether slot 15 wraps to slot 0 or runs on to slot 16. Reads start at a low index and at slot 15, and compare the leading count byte and the data against a queue of expected bytes. These reads also catch a wrong wrap, a wrong readback of the sense pins and stale data in reserved slots. The remaining patterns cover a foreign address, a read address sent with no index before it, a stop in the middle of a byte and a NACK on the count byte. They show whether the target acknowledges, stays silent or recovers when it should.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

  localparam logic [7:0] ADDR_WRITE = 8'hDC;
  localparam logic [7:0] ADDR_READ  = 8'hDD;
  localparam int unsigned SLOT_CTRL  = 0;
  localparam int unsigned SLOT_OEN   = 1;
  localparam int unsigned SLOT_STOP  = 2;
  localparam int unsigned SLOT_COUNT = 8;

  typedef enum logic [2:0] {
    PH_IDLE, PH_RX, PH_ACKPEND, PH_ACK, PH_TX, PH_RACK, PH_TXLOAD, PH_HOLD
  } smb_phase_e;

  typedef enum logic [1:0] {
    SG_ADDR, SG_INDEX, SG_COUNT, SG_WDATA
  } smb_stage_e;

  // reset value of each slot
  function automatic logic [7:0] slot_reset(int unsigned i);
    case (i)
      SLOT_CTRL:  return 8'h05;
      SLOT_OEN:   return 8'hFF;
      SLOT_COUNT: return 8'h09;
      default:    return 8'h00;
    endcase
  endfunction

  // bits that a write may change in each slot
  function automatic logic [7:0] slot_wmask(int unsigned i);
    case (i)
      SLOT_CTRL:  return 8'hE5;
      SLOT_OEN:   return 8'hFF;
      SLOT_STOP:  return 8'hFF;
      SLOT_COUNT: return 8'hFF;
      default:    return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/smb_line_front.sv
module smb_line_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_s, sda_s, scl_q, sda_q;

  assign scl_s = scl_ff[SYNC_STAGES-1];
  assign sda_s = sda_ff[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_comb begin
    sda_s_o    = sda_s;
    scl_rise_o = scl_s & ~scl_q;
    scl_fall_o = ~scl_s & scl_q;
    start_o    = scl_s & scl_q & sda_q & ~sda_s;
    stop_o     = scl_s & scl_q & ~sda_q & sda_s;
  end

endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
  import smb_cfg_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [7:0]       wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [7:0]       rd_data_o,
  input  logic [1:0]       sense_i,
  output logic [7:0]       ctrl_o,
  output logic [7:0]       oe_mask_o,
  output logic [7:0]       stop_sel_o,
  output logic [7:0]       cnt_o
);

  localparam int NSLOT = 1 << IDX_W;

  logic [7:0] slot_q [NSLOT];
  logic [7:0] view   [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    localparam logic [7:0] WMASK = slot_wmask(g);
    localparam logic [7:0] RVAL  = slot_reset(g);
    logic       we;
    logic [7:0] merged;
    logic [7:0] q_r;

    always_comb begin
      we     = wr_en_i && (wr_idx_i == IDX_W'(g));
      merged = (q_r & ~WMASK) | (wr_data_i & WMASK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q_r <= RVAL;
      else if (we) q_r <= merged;
    end

    assign slot_q[g] = q_r;
  end

  always_comb begin
    for (int k = 0; k < NSLOT; k++) view[k] = slot_q[k];
    view[SLOT_CTRL][3] = sense_i[1];
    view[SLOT_CTRL][1] = sense_i[0];
  end

  always_comb begin
    rd_data_o  = view[rd_idx_i];
    ctrl_o     = view[SLOT_CTRL];
    oe_mask_o  = slot_q[SLOT_OEN];
    stop_sel_o = slot_q[SLOT_STOP];
    cnt_o      = slot_q[SLOT_COUNT];
  end

endmodule

// File: rtl/smb_proto_fsm.sv
module smb_proto_fsm
  import smb_cfg_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_s_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [7:0]       rd_data_i,
  input  logic [7:0]       cnt_data_i,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [7:0]       wr_data_o,
  output logic             sda_oe_o
);

  smb_phase_e       phase_q, phase_n;
  smb_stage_e       stage_q, stage_n;
  logic [2:0]       bit_q, bit_n;
  logic [7:0]       sh_q, sh_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic             have_idx_q, have_idx_n;
  logic             rd_mode_q, rd_mode_n;
  logic             ack_q, ack_n;
  logic             cnt_phase_q, cnt_phase_n;
  logic             wr_en_q, wr_en_n;
  logic [IDX_W-1:0] wr_idx_q, wr_idx_n;
  logic [7:0]       wr_data_q, wr_data_n;
  logic [7:0]       rx_byte;

  assign rx_byte = {sh_q[6:0], sda_s_i};

  always_comb begin
    phase_n     = phase_q;
    stage_n     = stage_q;
    bit_n       = bit_q;
    sh_n        = sh_q;
    idx_n       = idx_q;
    have_idx_n  = have_idx_q;
    rd_mode_n   = rd_mode_q;
    ack_n       = ack_q;
    cnt_phase_n = cnt_phase_q;
    wr_en_n     = 1'b0;
    wr_idx_n    = wr_idx_q;
    wr_data_n   = wr_data_q;

    if (stop_i) begin
      phase_n    = PH_IDLE;
      have_idx_n = 1'b0;
      rd_mode_n  = 1'b0;
    end else if (start_i) begin
      phase_n   = PH_RX;
      stage_n   = SG_ADDR;
      bit_n     = 3'd0;
      rd_mode_n = 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE, PH_HOLD: ;
        PH_RX: if (scl_rise_i) begin
          sh_n  = rx_byte;
          bit_n = bit_q + 3'd1;
          if (bit_q == 3'd7) begin
            phase_n = PH_ACKPEND;
            ack_n   = 1'b1;
            unique case (stage_q)
              SG_ADDR: begin
                if (rx_byte == ADDR_WRITE) stage_n = SG_INDEX;
                else if (rx_byte == ADDR_READ && have_idx_q) rd_mode_n = 1'b1;
                else ack_n = 1'b0;
              end
              SG_INDEX: begin
                idx_n      = rx_byte[IDX_W-1:0];
                have_idx_n = 1'b1;
                stage_n    = SG_COUNT;
              end
              SG_COUNT: stage_n = SG_WDATA;
              SG_WDATA: begin
                wr_en_n   = 1'b1;
                wr_idx_n  = idx_q;
                wr_data_n = rx_byte;
                idx_n     = idx_q + 1'b1;
              end
              default: ;
            endcase
          end
        end
        PH_ACKPEND: if (scl_fall_i) phase_n = ack_q ? PH_ACK : PH_HOLD;
        PH_ACK: if (scl_fall_i) begin
          bit_n = 3'd0;
          if (rd_mode_q) begin
            sh_n        = cnt_data_i;
            cnt_phase_n = 1'b1;
            phase_n     = PH_TX;
          end else begin
            phase_n = PH_RX;
          end
        end
        PH_TX: if (scl_fall_i) begin
          if (bit_q == 3'd7) begin
            phase_n = PH_RACK;
          end else begin
            sh_n  = {sh_q[6:0], 1'b0};
            bit_n = bit_q + 3'd1;
          end
        end
        PH_RACK: if (scl_rise_i) begin
          if (!cnt_phase_q) idx_n = idx_q + 1'b1;
          cnt_phase_n = 1'b0;
          phase_n     = sda_s_i ? PH_HOLD : PH_TXLOAD;
        end
        PH_TXLOAD: if (scl_fall_i) begin
          sh_n    = rd_data_i;
          bit_n   = 3'd0;
          phase_n = PH_TX;
        end
        default: phase_n = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_IDLE;
      stage_q     <= SG_ADDR;
      bit_q       <= 3'd0;
      sh_q        <= 8'h00;
      idx_q       <= '0;
      have_idx_q  <= 1'b0;
      rd_mode_q   <= 1'b0;
      ack_q       <= 1'b0;
      cnt_phase_q <= 1'b0;
      wr_en_q     <= 1'b0;
      wr_idx_q    <= '0;
      wr_data_q   <= 8'h00;
    end else begin
      phase_q     <= phase_n;
      stage_q     <= stage_n;
      bit_q       <= bit_n;
      sh_q        <= sh_n;
      idx_q       <= idx_n;
      have_idx_q  <= have_idx_n;
      rd_mode_q   <= rd_mode_n;
      ack_q       <= ack_n;
      cnt_phase_q <= cnt_phase_n;
      wr_en_q     <= wr_en_n;
      wr_idx_q    <= wr_idx_n;
      wr_data_q   <= wr_data_n;
    end
  end

  always_comb begin
    rd_idx_o  = idx_q;
    wr_en_o   = wr_en_q;
    wr_idx_o  = wr_idx_q;
    wr_data_o = wr_data_q;
    sda_oe_o  = (phase_q == PH_ACK) | ((phase_q == PH_TX) & ~sh_q[7]);
  end

endmodule

// File: rtl/smb_cfg_target.sv
module smb_cfg_target #(
  parameter int IDX_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [1:0] sense_i,
  output logic [7:0] ctrl_o,
  output logic [7:0] oe_mask_o,
  output logic [7:0] stop_sel_o,
  output logic [7:0] xfer_cnt_o
);

  logic [1:0]       rst_pipe;
  logic             rst_core_n;
  logic             sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [7:0]       wr_data, rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  smb_line_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_core_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  smb_proto_fsm #(.IDX_W(IDX_W)) u_fsm (
    .clk(clk), .rst_n(rst_core_n), .sda_s_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det),
    .rd_data_i(rd_data), .cnt_data_i(xfer_cnt_o), .rd_idx_o(rd_idx),
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data),
    .sda_oe_o(sda_oe_o)
  );

  smb_reg_bank #(.IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_core_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .rd_idx_i(rd_idx), .rd_data_o(rd_data),
    .sense_i(sense_i), .ctrl_o(ctrl_o), .oe_mask_o(oe_mask_o),
    .stop_sel_o(stop_sel_o), .cnt_o(xfer_cnt_o)
  );

endmodule

// File: rtl/smb_cfg_target_chk.sv
module smb_cfg_target_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_rise,
  input logic             scl_fall,
  input logic             start_det,
  input logic             stop_det,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic             sda_oe,
  input logic [7:0]       oe_mask,
  input logic [7:0]       stop_sel,
  input logic [7:0]       cnt
);

  // R9
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R10
  sda_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall || start_det || stop_det));

  // R3
  wr_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(scl_rise));

  // R11
  oe_mask_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_mask) |-> $past(wr_en && wr_idx == IDX_W'(1)));

  // R11
  stop_sel_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stop_sel) |-> $past(wr_en && wr_idx == IDX_W'(2)));

  // R11
  cnt_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt) |-> $past(wr_en && wr_idx == IDX_W'(8)));

endmodule

bind smb_cfg_target smb_cfg_target_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_core_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
  .start_det(start_det), .stop_det(stop_det), .wr_en(wr_en),
  .wr_idx(wr_idx), .sda_oe(sda_oe_o), .oe_mask(oe_mask_o),
  .stop_sel(stop_sel_o), .cnt(xfer_cnt_o)
);

// File: tb/tb_smb_cfg_target.sv
module tb_smb_cfg_target;

  localparam int QTR = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic h_scl_lo = 1'b0;
  logic h_sda_lo = 1'b0;
  logic [1:0] sense = 2'b10;
  logic sda_oe;
  logic [7:0] ctrl, oe_mask, stop_sel, xcnt;
  logic scl_w, sda_w;

  int n_chk = 0;
  int n_fail = 0;
  int hi_changes = 0;

  typedef struct { logic [7:0] v; string req; } exp_t;
  exp_t       exp_q[$];
  logic [7:0] act_q[$];

  always #2.5 clk = ~clk;

  assign scl_w = ~h_scl_lo;
  assign sda_w = ~(h_sda_lo | sda_oe);

  smb_cfg_target dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_w), .sda_i(sda_w),
    .sda_oe_o(sda_oe), .sense_i(sense), .ctrl_o(ctrl),
    .oe_mask_o(oe_mask), .stop_sel_o(stop_sel), .xfer_cnt_o(xcnt)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compares bytes returned by the target against the queue
  initial begin
    forever begin
      @(negedge clk);
      if (act_q.size() > 0) begin
        logic [7:0] a;
        a = act_q.pop_front();
        if (exp_q.size() == 0) check("R5 unexpected byte", a, 8'hxx);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          check(e.req, a, e.v);
        end
      end
    end
  end

  // R10 monitor: target's SDA drive must not move while SCL stays high
  initial begin
    logic p_oe, p_scl;
    p_oe = 1'b0; p_scl = 1'b1;
    forever begin
      @(negedge clk);
      if (rst_n && scl_w && p_scl && sda_oe !== p_oe) hi_changes++;
      p_oe = sda_oe; p_scl = scl_w;
    end
  end

  task automatic q(); repeat (QTR) @(negedge clk); endtask

  task automatic bus_start();
    h_sda_lo = 1'b0; q();
    h_scl_lo = 1'b0; q();
    h_sda_lo = 1'b1; q();
    h_scl_lo = 1'b1; q();
  endtask

  task automatic bus_stop();
    h_sda_lo = 1'b1; q();
    h_scl_lo = 1'b0; q();
    h_sda_lo = 1'b0; q();
  endtask

  task automatic wr_bit(logic b);
    h_sda_lo = ~b; q();
    h_scl_lo = 1'b0; q(); q();
    h_scl_lo = 1'b1; q();
  endtask

  task automatic rd_bit(output logic b);
    h_sda_lo = 1'b0; q();
    h_scl_lo = 1'b0; q();
    b = sda_w; q();
    h_scl_lo = 1'b1; q();
  endtask

  task automatic wr_byte(logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) wr_bit(d[i]);
    rd_bit(s);
    ack = ~s;
  endtask

  task automatic rd_byte(logic host_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      rd_bit(b);
      d[i] = b;
    end
    wr_bit(~host_ack);
  endtask

  task automatic expect_rd(logic host_ack, logic [7:0] v, string req);
    logic [7:0] d;
    exp_q.push_back('{v: v, req: req});
    rd_byte(host_ack, d);
    act_q.push_back(d);
  endtask

  task automatic send(logic [7:0] d, logic exp_ack, string req);
    logic a;
    wr_byte(d, a);
    check(req, {7'd0, a}, {7'd0, exp_ack});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    logic b;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R1 reset state (readback has sense 2'b10 in bits 3 and 1)
    check("R1 ctrl", ctrl, 8'h0D);
    check("R1 oe_mask", oe_mask, 8'hFF);
    check("R1 stop_sel", stop_sel, 8'h00);
    check("R1 count", xcnt, 8'h09);
    check("R1 sda_oe", {7'd0, sda_oe}, 8'h00);

    // R2 R3 R4 write two bytes from index 1
    bus_start();
    send(8'hDC, 1'b1, "R2 write address ack");
    send(8'h01, 1'b1, "R3 index ack");
    send(8'h02, 1'b1, "R3 count ack");
    send(8'hA5, 1'b1, "R3 data ack");
    send(8'h3C, 1'b1, "R3 data ack");
    bus_stop();
    check("R3 slot1", oe_mask, 8'hA5);
    check("R4 slot2 after increment", stop_sel, 8'h3C);
    check("R3 count byte not stored", xcnt, 8'h09);

    // R7 write all ones to control
    bus_start();
    send(8'hDC, 1'b1, "R2 ack");
    send(8'h00, 1'b1, "R3 ack");
    send(8'h01, 1'b1, "R3 ack");
    send(8'hFF, 1'b1, "R7 data ack");
    bus_stop();
    check("R7 read-only and reserved bits", ctrl, 8'hED);

    // R4 R8 write slot 15 then wrap to slot 0
    bus_start();
    send(8'hDC, 1'b1, "R2 ack");
    send(8'h0F, 1'b1, "R4 ack");
    send(8'h02, 1'b1, "R3 ack");
    send(8'h11, 1'b1, "R8 ack");
    send(8'h00, 1'b1, "R4 ack");
    bus_stop();
    check("R4 wrap wrote slot 0", ctrl, 8'h08);

    // R5 set count register, R8 write reserved slot 3
    bus_start();
    send(8'hDC, 1'b1, "R2 ack");
    send(8'h08, 1'b1, "R5 ack");
    send(8'h01, 1'b1, "R5 ack");
    send(8'h04, 1'b1, "R5 ack");
    bus_stop();
    check("R5 count register", xcnt, 8'h04);
    bus_start();
    send(8'hDC, 1'b1, "R2 ack");
    send(8'h03, 1'b1, "R8 ack");
    send(8'h01, 1'b1, "R8 ack");
    send(8'h77, 1'b1, "R8 ack");
    bus_stop();

    // R5 R6 R8 read from index 1
    bus_start();
    send(8'hDC, 1'b1, "R2 ack");
    send(8'h01, 1'b1, "R5 ack");
    bus_start();
    send(8'hDD, 1'b1, "R5 read address ack");
    expect_rd(1'b1, 8'h04, "R5 count byte first");
    expect_rd(1'b1, 8'hA5, "R6 slot1 after ack");
    expect_rd(1'b1, 8'h3C, "R6 slot2");
    expect_rd(1'b0, 8'h00, "R8 reserved slot3");
    bus_stop();

    // R4 R7 R8 read across the wrap with new sense levels
    sense = 2'b01;
    bus_start();
    send(8'hDC, 1'b1, "R2 ack");
    send(8'h0F, 1'b1, "R4 ack");
    bus_start();
    send(8'hDD, 1'b1, "R5 ack");
    expect_rd(1'b1, 8'h04, "R5 count");
    expect_rd(1'b1, 8'h00, "R8 slot15");
    expect_rd(1'b0, 8'h02, "R7 R4 slot0 readback");
    bus_stop();

    // R2 foreign address: no ack, silent until stop
    bus_start();
    send(8'hA0, 1'b0, "R2 foreign address nack");
    send(8'hDC, 1'b0, "R2 silent until stop");
    bus_stop();
    check("R2 no side effect", oe_mask, 8'hA5);

    // R9 read address without an index
    bus_start();
    send(8'hDD, 1'b0, "R9 read without index nack");
    bus_stop();

    // R9 stop in the middle of a byte
    bus_start();
    send(8'hDC, 1'b1, "R2 ack");
    send(8'h02, 1'b1, "R9 ack");
    for (int i = 0; i < 4; i++) wr_bit(1'b0);
    bus_stop();
    check("R9 sda released after stop", {7'd0, sda_oe}, 8'h00);
    bus_start();
    send(8'hDC, 1'b1, "R9 recovery ack");
    send(8'h02, 1'b1, "R9 ack");
    send(8'h01, 1'b1, "R9 ack");
    send(8'h5A, 1'b1, "R9 ack");
    bus_stop();
    check("R9 write after recovery", stop_sel, 8'h5A);
    check("R11 other slot untouched", oe_mask, 8'hA5);

    // R6 NACK on the count byte releases SDA
    bus_start();
    send(8'hDC, 1'b1, "R2 ack");
    send(8'h00, 1'b1, "R6 ack");
    bus_start();
    send(8'hDD, 1'b1, "R6 ack");
    expect_rd(1'b0, 8'h04, "R6 count");
    rd_bit(b);
    check("R6 released after nack", {7'd0, b}, 8'h01);
    bus_stop();

    repeat (20) @(negedge clk);
    check("R10 drive changes with SCL high", hi_changes[7:0], 8'h00);
    check("R5 all expected bytes seen", exp_q.size() == 0 ? 8'h00 : 8'h01, 8'h00);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule